// File: doc/BRIEF.md
# Debug Entry Sequencer with Exception Deferral

This block decides when a processor core stops in halted debug state, why it stopped, and in which processor mode. It watches five kinds of event: breakpoint hits, watchpoint hits, external debug requests, exceptions (data abort, interrupt, others), and aborts on memory accesses that the debugger issues at system speed while the core is halted. The pipeline, register file and scan transport are not part of the block. They appear only as single-bit handshake inputs: instruction completed, mode changed, vector fetched, and restart.

A breakpoint or a plain watchpoint halts the core at once. A watchpoint that coincides with an exception is held back. The core must first switch into the exception's mode and fetch the instruction at the exception vector, and only then does it halt, in that exception mode. A debug request waits until the current instruction completes and flags that this instruction must not be refetched on resume. If a system-speed access aborts while the core is halted, the block leaves debug state. It waits for the core to take abort mode and fetch the abort vector, then halts again.

Top module: `dbg_entry_seq`

## Requirements
- R1: After reset, entry_o, active_o and no_refetch_o are 0, cause_o is 0 and entry_mode_o is 0.
- R2: From the running state, a breakpoint hit makes entry_o pulse and active_o rise on the next clock edge, with cause_o = 0 (breakpoint) and entry_mode_o equal to cur_mode_i as sampled with the hit.
- R3: A watchpoint hit with no exception in the same cycle enters debug on the next edge with cause_o = 1 and entry_mode_o = cur_mode_i.
- R4: A watchpoint hit together with a data abort causes no entry at first. The block waits for mode_chg_i, then for a later vec_fetch_i, and enters on the edge after vec_fetch_i with cause_o = 2 and entry_mode_o = ABT_MODE.
- R5: A watchpoint hit together with an interrupt or other exception, and no data abort, is deferred in the same way and enters with cause_o = 2 and entry_mode_o = exc_mode_i as sampled with the hit.
- R6: A debug request, whether present or latched from an earlier cycle, enters debug only on an edge where insn_done_i is 1. It gives cause_o = 3 and no_refetch_o = 1. Every other entry cause gives no_refetch_o = 0.
- R7: When causes coincide in one cycle, the priority is watchpoint with exception, then breakpoint, then watchpoint alone, then debug request.
- R8: entry_o is high for exactly one cycle per entry. active_o stays 1 until restart_i is sampled high, and then returns to 0 on the next edge.
- R9: While active_o is 1, sysacc_i and sysabt_i sampled high together clear active_o, even if restart_i is also high. The block then waits for mode_chg_i and then vec_fetch_i, and re-enters with cause_o = 4 and entry_mode_o = ABT_MODE. sysabt_i without sysacc_i has no effect.
- R10: After a restart, a new watchpoint hit on the refetched instruction enters debug again.
- R11: Breakpoint, watchpoint, exception and debug request inputs are ignored while debug is active or an entry is deferred. cause_o and entry_mode_o keep their values, and no entry_o pulse occurs.
- R12: While waiting for the mode change, vec_fetch_i has no effect. The vector fetch counts only after mode_chg_i has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_mode_i | input | MODE_W | Current processor mode |
| exc_mode_i | input | MODE_W | Mode of the pending non-abort exception |
| bp_hit_i | input | 1 | Breakpoint hit |
| wp_hit_i | input | 1 | Watchpoint hit |
| dbg_req_i | input | 1 | External debug request |
| insn_done_i | input | 1 | Current instruction has completed |
| exc_abort_i | input | 1 | Data abort on the current access |
| exc_irq_i | input | 1 | Interrupt taken |
| exc_other_i | input | 1 | Any other exception taken |
| mode_chg_i | input | 1 | Core has switched into the exception mode |
| vec_fetch_i | input | 1 | Instruction at the exception vector fetched |
| sysacc_i | input | 1 | System-speed access in progress while halted |
| sysabt_i | input | 1 | That access aborted |
| restart_i | input | 1 | Restart handshake from the debugger |
| entry_o | output | 1 | One-cycle debug entry strobe |
| active_o | output | 1 | Core is in debug state |
| cause_o | output | 3 | Entry cause: 0 bp, 1 wp, 2 wp+exception, 3 request, 4 system-speed abort |
| entry_mode_o | output | MODE_W | Mode in which debug was entered |
| no_refetch_o | output | 1 | Halted instruction must not be refetched on exit |

## Verification
The assertions check several properties on every cycle. The entry strobe is a single cycle and always comes with the active flag. The active flag falls only after a restart or an aborted system-speed access. Deferred entries follow a vector fetch, and a request entry follows a completed instruction with the no-refetch flag set. The recorded cause and mode stay frozen while the core is halted. Other behaviour needs the bench's scenarios, each compared against a cycle-level reference model: the priority among coinciding causes, the choice of abort mode versus the exception's own mode, the mode-then-vector ordering, the latching of an early request, and re-entry after a restart.

// File: rtl/dbg_entry_seq.sv
module dbg_entry_seq #(
  parameter int MODE_W = 5,
  parameter logic [MODE_W-1:0] ABT_MODE = 5'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic [MODE_W-1:0] exc_mode_i,
  input  logic              bp_hit_i,
  input  logic              wp_hit_i,
  input  logic              dbg_req_i,
  input  logic              insn_done_i,
  input  logic              exc_abort_i,
  input  logic              exc_irq_i,
  input  logic              exc_other_i,
  input  logic              mode_chg_i,
  input  logic              vec_fetch_i,
  input  logic              sysacc_i,
  input  logic              sysabt_i,
  input  logic              restart_i,
  output logic              entry_o,
  output logic              active_o,
  output logic [2:0]        cause_o,
  output logic [MODE_W-1:0] entry_mode_o,
  output logic              no_refetch_o
);

  localparam logic [2:0] C_BP   = 3'd0;
  localparam logic [2:0] C_WP   = 3'd1;
  localparam logic [2:0] C_WPEX = 3'd2;
  localparam logic [2:0] C_REQ  = 3'd3;
  localparam logic [2:0] C_SABT = 3'd4;

  typedef enum logic [1:0] {S_RUN, S_WMODE, S_WVEC, S_HALT} st_t;

  st_t              st;
  logic             req_pend;
  logic [2:0]       pend_cause;
  logic [MODE_W-1:0] pend_mode;

  logic              exc_any;
  logic              req_seen;
  logic              defer;
  logic              take;
  logic [2:0]        take_cause;
  logic [MODE_W-1:0] take_mode;

  assign exc_any  = exc_abort_i | exc_irq_i | exc_other_i;
  assign req_seen = dbg_req_i | req_pend;
  assign defer    = (st == S_RUN) & wp_hit_i & exc_any;

  always_comb begin
    take       = 1'b0;
    take_cause = C_BP;
    take_mode  = cur_mode_i;
    if (st == S_RUN && !defer) begin
      if (bp_hit_i) begin
        take       = 1'b1;
        take_cause = C_BP;
      end else if (wp_hit_i) begin
        take       = 1'b1;
        take_cause = C_WP;
      end else if (req_seen && insn_done_i) begin
        take       = 1'b1;
        take_cause = C_REQ;
      end
    end else if (st == S_WVEC && vec_fetch_i) begin
      take       = 1'b1;
      take_cause = pend_cause;
      take_mode  = pend_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_RUN;
      req_pend     <= 1'b0;
      pend_cause   <= C_BP;
      pend_mode    <= '0;
      entry_o      <= 1'b0;
      cause_o      <= C_BP;
      entry_mode_o <= '0;
      no_refetch_o <= 1'b0;
    end else begin
      entry_o <= 1'b0;
      if (take) begin
        st           <= S_HALT;
        entry_o      <= 1'b1;
        cause_o      <= take_cause;
        entry_mode_o <= take_mode;
        no_refetch_o <= (take_cause == C_REQ);
        req_pend     <= 1'b0;
      end else begin
        case (st)
          S_RUN: begin
            if (defer) begin
              st         <= S_WMODE;
              pend_cause <= C_WPEX;
              pend_mode  <= exc_abort_i ? ABT_MODE : exc_mode_i;
            end
            if (dbg_req_i) req_pend <= 1'b1;
          end
          S_WMODE: if (mode_chg_i) st <= S_WVEC;
          S_WVEC:  ;
          S_HALT: begin
            if (sysacc_i && sysabt_i) begin
              st         <= S_WMODE;
              pend_cause <= C_SABT;
              pend_mode  <= ABT_MODE;
            end else if (restart_i) begin
              st <= S_RUN;
            end
          end
          default: st <= S_RUN;
        endcase
      end
    end
  end

  assign active_o = (st == S_HALT);

endmodule

// File: rtl/dbg_entry_seq_chk.sv
module dbg_entry_seq_chk #(
  parameter int MODE_W = 5,
  parameter logic [MODE_W-1:0] ABT_MODE = 5'h17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_done_i,
  input logic              vec_fetch_i,
  input logic              sysacc_i,
  input logic              sysabt_i,
  input logic              restart_i,
  input logic              entry_o,
  input logic              active_o,
  input logic [2:0]        cause_o,
  input logic [MODE_W-1:0] entry_mode_o,
  input logic              no_refetch_o
);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |=> !entry_o);

  assert_strobe_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> active_o);

  assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> ($past(restart_i) || $past(sysacc_i && sysabt_i)));

  assert_deferred_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && cause_o == 3'd2) |-> $past(vec_fetch_i));

  assert_sysabt_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && cause_o == 3'd4) |-> (entry_mode_o == ABT_MODE && $past(vec_fetch_i)));

  assert_req_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && cause_o == 3'd3) |-> ($past(insn_done_i) && no_refetch_o));

  assert_refetch_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && cause_o != 3'd3) |-> !no_refetch_o);

  assert_fields_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !entry_o) |-> ($stable(cause_o) && $stable(entry_mode_o)));

endmodule

bind dbg_entry_seq dbg_entry_seq_chk #(.MODE_W(MODE_W), .ABT_MODE(ABT_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_done_i(insn_done_i), .vec_fetch_i(vec_fetch_i),
  .sysacc_i(sysacc_i), .sysabt_i(sysabt_i), .restart_i(restart_i),
  .entry_o(entry_o), .active_o(active_o), .cause_o(cause_o),
  .entry_mode_o(entry_mode_o), .no_refetch_o(no_refetch_o)
);

// File: tb/dbg_entry_seq_bench.sv
`timescale 1ns/1ps
module dbg_entry_seq_bench;
  localparam int MW = 5;
  localparam logic [MW-1:0] ABT = 5'h17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [MW-1:0] cur_mode = 5'h10, exc_mode = 5'h12;
  logic bp = 0, wp = 0, req = 0, done = 0, eab = 0, eirq = 0, eoth = 0;
  logic mchg = 0, vfetch = 0, sacc = 0, sabt = 0, rst_req = 0;
  logic entry, active, nrf;
  logic [2:0] cause;
  logic [MW-1:0] emode;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  dbg_entry_seq #(.MODE_W(MW), .ABT_MODE(ABT)) u_dbg_entry_seq (
    .clk(clk), .rst_n(rst_n), .cur_mode_i(cur_mode), .exc_mode_i(exc_mode),
    .bp_hit_i(bp), .wp_hit_i(wp), .dbg_req_i(req), .insn_done_i(done),
    .exc_abort_i(eab), .exc_irq_i(eirq), .exc_other_i(eoth),
    .mode_chg_i(mchg), .vec_fetch_i(vfetch), .sysacc_i(sacc), .sysabt_i(sabt),
    .restart_i(rst_req), .entry_o(entry), .active_o(active), .cause_o(cause),
    .entry_mode_o(emode), .no_refetch_o(nrf)
  );

  // Behavioural reference: phase 0 running, 1 awaiting mode, 2 awaiting vector, 3 halted
  int phase = 0;
  bit m_entry = 0, m_pend_req = 0, m_nrf = 0;
  int m_cause = 0, m_mode = 0, p_cause = 0, p_mode = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; m_entry = 0; m_pend_req = 0; m_nrf = 0;
      m_cause = 0; m_mode = 0; p_cause = 0; p_mode = 0;
    end else begin
      int nc;
      bit go;
      go = 0; nc = 0;
      m_entry = 0;
      if (phase == 0) begin
        if (wp && (eab || eirq || eoth)) begin
          phase = 1; p_cause = 2; p_mode = eab ? int'(ABT) : int'(exc_mode);
          if (req) m_pend_req = 1;
        end else if (bp) begin go = 1; nc = 0; p_mode = cur_mode; end
        else if (wp) begin go = 1; nc = 1; p_mode = cur_mode; end
        else if ((req || m_pend_req) && done) begin go = 1; nc = 3; p_mode = cur_mode; end
        else if (req) m_pend_req = 1;
      end else if (phase == 1) begin
        if (mchg) phase = 2;
      end else if (phase == 2) begin
        if (vfetch) begin go = 1; nc = p_cause; end
      end else begin
        if (sacc && sabt) begin phase = 1; p_cause = 4; p_mode = ABT; end
        else if (rst_req) phase = 0;
      end
      if (go) begin
        phase = 3; m_entry = 1; m_cause = nc; m_mode = p_mode;
        m_nrf = (nc == 3); m_pend_req = 0;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("entry_o", entry, m_entry);
      check("active_o", active, phase == 3);
      check("cause_o", cause, m_cause);
      check("entry_mode_o", emode, m_mode);
      check("no_refetch_o", nrf, m_nrf);
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(negedge clk); #1;
      bp = 0; wp = 0; req = 0; done = 0; eab = 0; eirq = 0; eoth = 0;
      mchg = 0; vfetch = 0; sacc = 0; sabt = 0; rst_req = 0;
    end
  endtask

  task automatic restart();
    rst_req = 1; tick(); tick(2);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    cur_req = "R1";
    check("reset entry", entry, 0); check("reset active", active, 0);
    check("reset cause", cause, 0); check("reset mode", emode, 0);
    check("reset nrf", nrf, 0);

    cur_req = "R2"; cur_mode = 5'h13; bp = 1; tick(); tick(3);
    cur_req = "R8"; restart();

    cur_req = "R3"; cur_mode = 5'h1f; wp = 1; tick(); tick(2);
    cur_req = "R11"; bp = 1; wp = 1; req = 1; done = 1; eab = 1; tick(); tick(2);
    restart();

    cur_req = "R4"; cur_mode = 5'h10; wp = 1; eab = 1; tick(); tick(3);
    cur_req = "R12"; vfetch = 1; tick(); tick(2);
    cur_req = "R11"; bp = 1; tick(); tick();
    cur_req = "R4"; mchg = 1; tick(); tick(2); vfetch = 1; tick(); tick(2);
    restart();
    cur_req = "R10"; wp = 1; tick(); tick(2); restart();

    cur_req = "R5"; exc_mode = 5'h12; wp = 1; eirq = 1; tick(); tick();
    mchg = 1; vfetch = 1; tick(); tick(); vfetch = 1; tick(); tick(2); restart();
    exc_mode = 5'h11; wp = 1; eoth = 1; tick(); mchg = 1; tick(); vfetch = 1; tick(); tick(2);
    restart();

    cur_req = "R6"; cur_mode = 5'h10; req = 1; tick(); tick(4); done = 1; tick(); tick(2);
    restart();
    req = 1; done = 1; tick(); tick(2); restart();

    cur_req = "R7"; wp = 1; eab = 1; bp = 1; req = 1; done = 1; tick(); tick();
    mchg = 1; tick(); vfetch = 1; tick(); tick(); restart();
    bp = 1; wp = 1; req = 1; done = 1; tick(); tick(); restart();
    wp = 1; req = 1; done = 1; tick(); tick(); restart();

    cur_req = "R9"; bp = 1; tick(); tick();
    sabt = 1; tick(); tick(); sacc = 1; tick(); tick();
    sacc = 1; sabt = 1; rst_req = 1; tick(); tick(2);
    mchg = 1; tick(); tick(); vfetch = 1; tick(); tick(3);
    restart(); tick(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule